// File: doc/BRIEF.md
# Environment-Configuration Access Gate

This block sits beside the control-register file of a core that supports hypervisor virtualization. It holds the supervisor environment-configuration register and the hypervisor environment-configuration register, a 64-bit register that is also reachable through a separate upper-half view. It also holds three 64-bit state-enable registers, one for each of the machine, hypervisor and supervisor levels. Every access to one of the environment-configuration views is screened against the envcfg-enable bit of the three state-enable registers. The screen also uses the current privilege level and the virtualization mode.

A decoded access request arrives with a target, a read/write flag and write data. One clock later the block answers with a fault code and, for an allowed access, the read data. Write masks for the state-enable registers and for each envcfg view are applied here, so software-visible reserved bits always read as zero. The trap-entry logic consumes the fault code. The address decoder upstream produces the request.

Top module: `envcfg_access_gate`

## Requirements
- R1: An access made at machine privilege (priv = 2'b11) always completes with fault code none (2'b00), whatever the state-enable registers hold.
- R2: When the state-enable feature input `cfg_sten_on` is low, every access completes with fault code none at any privilege.
- R3: Below machine privilege, with the feature on, a clear envcfg-enable bit (bit 62) in the machine state-enable register gives fault code illegal (2'b01), in both virtual and non-virtual modes.
- R4: With `virt` high and the machine bit set, a clear bit 62 in the hypervisor state-enable register gives fault code virtual (2'b10). With `virt` low the hypervisor register is not consulted.
- R5: At user privilege (priv = 2'b00) with `cfg_has_smode` high, a clear bit 62 in the supervisor state-enable register faults. The fault is illegal when `virt` is low and virtual when `virt` is high. Supervisor privilege (2'b01) and a core without supervisor mode skip this level.
- R6: The levels are screened machine first, then hypervisor, then supervisor, and the first failing level alone picks the fault code.
- R7: A write to the supervisor envcfg view (target 0) changes only bits 0, 4, 5, 6 and 7. Every other bit keeps its value, and a read returns the whole register.
- R8: A write to the hypervisor envcfg view (target 1) changes bits 0 and 4..7, and also bits 62 and 63 when `cfg_rv64` is high. A read returns all 64 bits when `cfg_rv64` is high and only bits 31:0, zero-extended, when it is low.
- R9: The upper-half view (target 2) reads hypervisor bits 63:32 in rdata bits 31:0. A write moves written bits 31:30 into bits 63:62 and leaves every other bit alone.
- R10: Each state-enable register keeps only bits 63 and 62 and reads all other bits as zero. A full write (`sten_wr_hi` low) loads data bits 63:62. An upper-half write (`sten_wr_hi` high) loads data bits 31:30 into bits 63:62.
- R11: A faulting access returns read data zero and leaves both envcfg registers unchanged.
- R12: The response (`rsp_valid`, `rsp_fault`, `rsp_rdata`) appears in the cycle after the request was sampled and lasts one cycle. Fault code none is reported whenever `rsp_valid` is low. After reset every register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sten_on | input | 1 | State-enable feature present and active |
| cfg_has_smode | input | 1 | Supervisor privilege implemented |
| cfg_rv64 | input | 1 | 64-bit register width mode |
| priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| virt | input | 1 | Virtualization mode active |
| sten_wr_en | input | 1 | Write strobe for a state-enable register |
| sten_wr_level | input | 2 | Level written: 0 machine, 1 hypervisor, 2 supervisor |
| sten_wr_hi | input | 1 | Write targets the upper half |
| sten_wr_data | input | 64 | State-enable write data |
| sten_rd_level | input | 2 | Level shown on sten_rd_data |
| sten_rd_data | output | 64 | Contents of the selected state-enable register |
| acc_valid | input | 1 | Envcfg access request |
| acc_write | input | 1 | Request is a write |
| acc_target | input | 2 | 0 supervisor envcfg, 1 hypervisor envcfg, 2 hypervisor upper half |
| acc_wdata | input | 64 | Envcfg write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 2 | 00 none, 01 illegal, 10 virtual |
| rsp_rdata | output | 64 | Read data, zero on fault |

## Verification
The assertions assume the privilege input never carries the reserved code 2'b10. They also assume the access target is one of the three defined views. The bench only drives the three defined privilege codes and targets 0 to 2. It never issues a state-enable write in the same cycle as an envcfg access. This keeps the decision of every access tied to register contents that were settled a cycle earlier. Configuration inputs change only between requests, never while a response is pending.

// File: rtl/envgate_pkg.sv
package envgate_pkg;

    localparam int REG_W      = 64;
    localparam int HALF_W     = REG_W / 2;
    localparam int NUM_LEVELS = 3;
    localparam int LVL_W      = $clog2(NUM_LEVELS);

    localparam int STEN_ALL_BIT = REG_W - 1;
    localparam int STEN_ENV_BIT = REG_W - 2;

    localparam int ENV_FIOM_BIT   = 0;
    localparam int ENV_CBIE_LO    = 4;
    localparam int ENV_CBCFE_BIT  = 6;
    localparam int ENV_CBZE_BIT   = 7;
    localparam int ENV_PBMTE_BIT  = 62;
    localparam int ENV_STCE_BIT   = 63;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_ILLEGAL = 2'b01,
        FLT_VIRTUAL = 2'b10
    } fault_e;

    typedef enum logic [1:0] {
        TGT_SENV  = 2'd0,
        TGT_HENV  = 2'd1,
        TGT_HENVH = 2'd2
    } target_e;

    typedef struct packed {
        logic              valid;
        fault_e            fault;
        logic [REG_W-1:0]  rdata;
    } resp_t;

    localparam logic [REG_W-1:0] STEN_WMASK =
        (REG_W'(1) << STEN_ALL_BIT) | (REG_W'(1) << STEN_ENV_BIT);

    function automatic logic [REG_W-1:0] env_base_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[ENV_FIOM_BIT]                  = 1'b1;
        m[ENV_CBIE_LO+1:ENV_CBIE_LO]     = 2'b11;
        m[ENV_CBCFE_BIT]                 = 1'b1;
        m[ENV_CBZE_BIT]                  = 1'b1;
        return m;
    endfunction

    function automatic logic [REG_W-1:0] env_upper_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[ENV_PBMTE_BIT] = 1'b1;
        m[ENV_STCE_BIT]  = 1'b1;
        return m;
    endfunction

    function automatic logic [REG_W-1:0] merge_masked(
        input logic [REG_W-1:0] old_v,
        input logic [REG_W-1:0] new_v,
        input logic [REG_W-1:0] mask
    );
        return (old_v & ~mask) | (new_v & mask);
    endfunction

endpackage

// File: rtl/sten_bank.sv
module sten_bank
    import envgate_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [LVL_W-1:0]      wr_level,
    input  logic                  wr_hi,
    input  logic [REG_W-1:0]      wr_data,
    input  logic [LVL_W-1:0]      rd_level,
    output logic [REG_W-1:0]      rd_data,
    output logic [NUM_LEVELS-1:0] env_en
);

    logic [REG_W-1:0] regs_q [NUM_LEVELS];

    logic [REG_W-1:0] wr_aligned;
    assign wr_aligned = wr_hi ? {wr_data[HALF_W-1:0], {HALF_W{1'b0}}} : wr_data;

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (wr_en && (wr_level == LVL_W'(g))) begin
                regs_q[g] <= wr_aligned & STEN_WMASK;
            end
        end
        assign env_en[g] = regs_q[g][STEN_ENV_BIT];

        AST_STEN_RESERVED: assert property (@(posedge clk) disable iff (rst)
            (regs_q[g] & ~STEN_WMASK) == '0);  // R10
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if (rd_level == LVL_W'(i)) rd_data = regs_q[i];
        end
    end

endmodule

// File: rtl/gate_decide.sv
module gate_decide
    import envgate_pkg::*;
(
    input  logic                  sten_on,
    input  logic                  has_smode,
    input  logic [1:0]            priv,
    input  logic                  virt,
    input  logic [NUM_LEVELS-1:0] env_en,
    output fault_e                fault
);

    logic m_fail, h_fail, s_fail;

    always_comb begin
        m_fail = !env_en[0];
        h_fail = virt && !env_en[1];
        s_fail = (priv == PRIV_U) && has_smode && !env_en[2];

        if (priv == PRIV_M || !sten_on) begin
            fault = FLT_NONE;
        end else if (m_fail) begin
            fault = FLT_ILLEGAL;
        end else if (h_fail) begin
            fault = FLT_VIRTUAL;
        end else if (s_fail) begin
            fault = virt ? FLT_VIRTUAL : FLT_ILLEGAL;
        end else begin
            fault = FLT_NONE;
        end
    end

endmodule

// File: rtl/envcfg_bank.sv
module envcfg_bank
    import envgate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rv64,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [1:0]       acc_target,
    input  logic [REG_W-1:0] acc_wdata,
    input  fault_e           fault,
    output resp_t            resp
);

    logic [REG_W-1:0] senv_q, henv_q;
    logic [REG_W-1:0] henv_wmask;
    logic [REG_W-1:0] rd_val;
    logic             allowed;

    assign allowed    = acc_valid && (fault == FLT_NONE);
    assign henv_wmask = env_base_mask() | (rv64 ? env_upper_mask() : '0);

    always_comb begin
        case (acc_target)
            TGT_SENV:  rd_val = senv_q;
            TGT_HENV:  rd_val = rv64 ? henv_q : {{HALF_W{1'b0}}, henv_q[HALF_W-1:0]};
            TGT_HENVH: rd_val = {{HALF_W{1'b0}}, henv_q[REG_W-1:HALF_W]};
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            senv_q <= '0;
            henv_q <= '0;
            resp   <= '{valid: 1'b0, fault: FLT_NONE, rdata: '0};
        end else begin
            resp.valid <= acc_valid;
            resp.fault <= acc_valid ? fault : FLT_NONE;
            resp.rdata <= allowed ? rd_val : '0;
            if (allowed && acc_write) begin
                case (acc_target)
                    TGT_SENV:  senv_q <= merge_masked(senv_q, acc_wdata, env_base_mask());
                    TGT_HENV:  henv_q <= merge_masked(henv_q, acc_wdata, henv_wmask);
                    TGT_HENVH: henv_q <= merge_masked(henv_q,
                                   {acc_wdata[HALF_W-1:0], {HALF_W{1'b0}}}, env_upper_mask());
                    default: ;
                endcase
            end
        end
    end

    AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (resp.fault != FLT_NONE) |-> (resp.rdata == '0));  // R11
    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && fault != FLT_NONE) |=> ($stable(senv_q) && $stable(henv_q)));  // R11
    AST_SENV_RESERVED: assert property (@(posedge clk) disable iff (rst)
        (senv_q & ~env_base_mask()) == '0);  // R7
    AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        !resp.valid |-> (resp.fault == FLT_NONE));  // R12

endmodule

// File: rtl/envcfg_access_gate.sv
module envcfg_access_gate
    import envgate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_sten_on,
    input  logic        cfg_has_smode,
    input  logic        cfg_rv64,
    input  logic [1:0]  priv,
    input  logic        virt,
    input  logic        sten_wr_en,
    input  logic [1:0]  sten_wr_level,
    input  logic        sten_wr_hi,
    input  logic [63:0] sten_wr_data,
    input  logic [1:0]  sten_rd_level,
    output logic [63:0] sten_rd_data,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [1:0]  acc_target,
    input  logic [63:0] acc_wdata,
    output logic        rsp_valid,
    output logic [1:0]  rsp_fault,
    output logic [63:0] rsp_rdata
);

    logic [NUM_LEVELS-1:0] env_en;
    fault_e                fault;
    resp_t                 resp;

    sten_bank u_sten (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (sten_wr_en),
        .wr_level (sten_wr_level),
        .wr_hi    (sten_wr_hi),
        .wr_data  (sten_wr_data),
        .rd_level (sten_rd_level),
        .rd_data  (sten_rd_data),
        .env_en   (env_en)
    );

    gate_decide u_decide (
        .sten_on   (cfg_sten_on),
        .has_smode (cfg_has_smode),
        .priv      (priv),
        .virt      (virt),
        .env_en    (env_en),
        .fault     (fault)
    );

    envcfg_bank u_env (
        .clk        (clk),
        .rst        (rst),
        .rv64       (cfg_rv64),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_target (acc_target),
        .acc_wdata  (acc_wdata),
        .fault      (fault),
        .resp       (resp)
    );

    assign rsp_valid = resp.valid;
    assign rsp_fault = resp.fault;
    assign rsp_rdata = resp.rdata;

    AST_MACHINE_FREE: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && priv == PRIV_M) |=> (rsp_fault == FLT_NONE));  // R1
    AST_FEATURE_OFF_FREE: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !cfg_sten_on) |=> (rsp_fault == FLT_NONE));  // R2
    AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_valid);  // R12
    AST_MLEVEL_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && cfg_sten_on && priv != PRIV_M && !sten_wr_en && sten_rd_level == 2'd0
         && sten_rd_data[STEN_ENV_BIT] == 1'b0) |=> (rsp_fault == FLT_ILLEGAL));  // R3

endmodule

// File: tb/test_envcfg_access_gate.sv
`timescale 1ns/1ps
module test_envcfg_access_gate;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_sten_on, cfg_has_smode, cfg_rv64;
    logic [1:0]  priv;
    logic        virt;
    logic        sten_wr_en, sten_wr_hi;
    logic [1:0]  sten_wr_level, sten_rd_level;
    logic [63:0] sten_wr_data, sten_rd_data;
    logic        acc_valid, acc_write;
    logic [1:0]  acc_target;
    logic [63:0] acc_wdata;
    logic        rsp_valid;
    logic [1:0]  rsp_fault;
    logic [63:0] rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [63:0] BOTH = 64'hC000_0000_0000_0000;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    always #4 clk = ~clk;

    envcfg_access_gate i_envcfg_access_gate (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sten_write(input logic [1:0] lvl, input logic hi, input logic [63:0] d);
        sten_wr_en = 1'b1; sten_wr_level = lvl; sten_wr_hi = hi; sten_wr_data = d;
        @(posedge clk); @(negedge clk);
        sten_wr_en = 1'b0; sten_wr_hi = 1'b0;
    endtask

    task automatic set_all(input logic m, input logic h, input logic s);
        sten_write(2'd0, 1'b0, m ? BOTH : 64'd0);
        sten_write(2'd1, 1'b0, h ? BOTH : 64'd0);
        sten_write(2'd2, 1'b0, s ? BOTH : 64'd0);
    endtask

    task automatic access(input logic [1:0] tgt, input logic wr, input logic [63:0] wd,
                          output logic [1:0] flt, output logic [63:0] rd);
        acc_valid = 1'b1; acc_target = tgt; acc_write = wr; acc_wdata = wd;
        @(posedge clk); @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        chk("R12 response strobe", 64'(rsp_valid), 64'd1);
        flt = rsp_fault; rd = rsp_rdata;
    endtask

    task automatic mode(input logic [1:0] p, input logic v);
        priv = p; virt = v;
    endtask

    task automatic t_reset();
        logic [1:0] f; logic [63:0] d;
        chk("R12 reset valid", 64'(rsp_valid), 64'd0);
        for (int l = 0; l < 3; l++) begin
            sten_rd_level = 2'(l); #1;
            chk("R12 reset stateen", sten_rd_data, 64'd0);
        end
        mode(2'b11, 1'b0);
        access(2'd1, 1'b0, 64'd0, f, d);
        chk("R12 reset henv", d, 64'd0);
        @(negedge clk);
        chk("R12 single-cycle strobe", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_sten_mask();
        sten_write(2'd0, 1'b0, ONES);
        sten_rd_level = 2'd0; #1;
        chk("R10 full write mask", sten_rd_data, BOTH);
        sten_write(2'd1, 1'b1, 64'h0000_0000_FFFF_FFFF);
        sten_rd_level = 2'd1; #1;
        chk("R10 upper-half write", sten_rd_data, BOTH);
        sten_write(2'd1, 1'b1, 64'h0000_0000_4000_0000);
        #1;
        chk("R10 upper-half partial", sten_rd_data, 64'h4000_0000_0000_0000);
        sten_write(2'd2, 1'b0, 64'h3FFF_FFFF_FFFF_FFFF);
        sten_rd_level = 2'd2; #1;
        chk("R10 reserved bits zero", sten_rd_data, 64'd0);
    endtask

    task automatic t_machine();
        logic [1:0] f; logic [63:0] d;
        set_all(1'b0, 1'b0, 1'b0);
        mode(2'b11, 1'b0);
        access(2'd0, 1'b0, 64'd0, f, d);
        chk("R1 machine free", 64'(f), 64'd0);
    endtask

    task automatic t_disabled();
        logic [1:0] f; logic [63:0] d;
        cfg_sten_on = 1'b0;
        mode(2'b00, 1'b1);
        access(2'd0, 1'b0, 64'd0, f, d);
        chk("R2 feature off user", 64'(f), 64'd0);
        mode(2'b01, 1'b0);
        access(2'd2, 1'b0, 64'd0, f, d);
        chk("R2 feature off super", 64'(f), 64'd0);
        cfg_sten_on = 1'b1;
    endtask

    task automatic t_mlevel();
        logic [1:0] f; logic [63:0] d;
        set_all(1'b0, 1'b1, 1'b1);
        mode(2'b01, 1'b0);
        access(2'd0, 1'b0, 64'd0, f, d);
        chk("R3 super machine bit clear", 64'(f), 64'd1);
        mode(2'b00, 1'b1);
        access(2'd1, 1'b0, 64'd0, f, d);
        chk("R3 vuser machine bit clear", 64'(f), 64'd1);
    endtask

    task automatic t_hlevel();
        logic [1:0] f; logic [63:0] d;
        set_all(1'b1, 1'b0, 1'b1);
        mode(2'b01, 1'b1);
        access(2'd0, 1'b0, 64'd0, f, d);
        chk("R4 vsuper hyp bit clear", 64'(f), 64'd2);
        mode(2'b01, 1'b0);
        access(2'd0, 1'b0, 64'd0, f, d);
        chk("R4 non-virtual skips hyp", 64'(f), 64'd0);
    endtask

    task automatic t_slevel();
        logic [1:0] f; logic [63:0] d;
        set_all(1'b1, 1'b1, 1'b0);
        mode(2'b00, 1'b0);
        access(2'd0, 1'b0, 64'd0, f, d);
        chk("R5 user sup bit clear", 64'(f), 64'd1);
        mode(2'b00, 1'b1);
        access(2'd0, 1'b0, 64'd0, f, d);
        chk("R5 vuser sup bit clear", 64'(f), 64'd2);
        mode(2'b01, 1'b1);
        access(2'd0, 1'b0, 64'd0, f, d);
        chk("R5 super skips sup level", 64'(f), 64'd0);
        cfg_has_smode = 1'b0;
        mode(2'b00, 1'b0);
        access(2'd0, 1'b0, 64'd0, f, d);
        chk("R5 no smode skips level", 64'(f), 64'd0);
        cfg_has_smode = 1'b1;
    endtask

    task automatic t_order();
        logic [1:0] f; logic [63:0] d;
        set_all(1'b0, 1'b0, 1'b0);
        mode(2'b00, 1'b1);
        access(2'd0, 1'b0, 64'd0, f, d);
        chk("R6 machine level first", 64'(f), 64'd1);
        set_all(1'b1, 1'b0, 1'b0);
        mode(2'b00, 1'b0);
        access(2'd0, 1'b0, 64'd0, f, d);
        chk("R6 hyp skipped falls to sup", 64'(f), 64'd1);
        set_all(1'b1, 1'b0, 1'b1);
        mode(2'b00, 1'b1);
        access(2'd0, 1'b0, 64'd0, f, d);
        chk("R6 hyp before sup", 64'(f), 64'd2);
    endtask

    task automatic t_senv();
        logic [1:0] f; logic [63:0] d;
        mode(2'b11, 1'b0);
        access(2'd0, 1'b1, ONES, f, d);
        access(2'd0, 1'b0, 64'd0, f, d);
        chk("R7 senv write mask", d, 64'h0000_0000_0000_00F1);
        access(2'd0, 1'b1, 64'h0000_0000_0000_0010, f, d);
        access(2'd0, 1'b0, 64'd0, f, d);
        chk("R7 senv partial", d, 64'h0000_0000_0000_0010);
    endtask

    task automatic t_henv();
        logic [1:0] f; logic [63:0] d;
        mode(2'b11, 1'b0);
        cfg_rv64 = 1'b1;
        access(2'd1, 1'b1, ONES, f, d);
        access(2'd1, 1'b0, 64'd0, f, d);
        chk("R8 henv rv64 mask", d, 64'hC000_0000_0000_00F1);
        access(2'd1, 1'b1, 64'd0, f, d);
        cfg_rv64 = 1'b0;
        access(2'd1, 1'b1, ONES, f, d);
        access(2'd1, 1'b0, 64'd0, f, d);
        chk("R8 henv rv32 read", d, 64'h0000_0000_0000_00F1);
        cfg_rv64 = 1'b1;
        access(2'd1, 1'b0, 64'd0, f, d);
        chk("R8 rv32 write left upper bits", d, 64'h0000_0000_0000_00F1);
    endtask

    task automatic t_henvh();
        logic [1:0] f; logic [63:0] d;
        mode(2'b11, 1'b0);
        access(2'd2, 1'b1, 64'h0000_0000_FFFF_FFFF, f, d);
        access(2'd2, 1'b0, 64'd0, f, d);
        chk("R9 upper view read", d, 64'h0000_0000_C000_0000);
        access(2'd1, 1'b0, 64'd0, f, d);
        chk("R9 low bits untouched", d, 64'hC000_0000_0000_00F1);
        access(2'd2, 1'b1, 64'h0000_0000_4000_0000, f, d);
        access(2'd2, 1'b0, 64'd0, f, d);
        chk("R9 upper partial", d, 64'h0000_0000_4000_0000);
    endtask

    task automatic t_fault_nowrite();
        logic [1:0] f; logic [63:0] d;
        set_all(1'b0, 1'b1, 1'b1);
        mode(2'b00, 1'b0);
        access(2'd0, 1'b1, 64'd0, f, d);
        chk("R11 fault code", 64'(f), 64'd1);
        access(2'd1, 1'b0, 64'd0, f, d);
        chk("R11 fault data zero", d, 64'd0);
        mode(2'b11, 1'b0);
        access(2'd0, 1'b0, 64'd0, f, d);
        chk("R11 senv unchanged", d, 64'h0000_0000_0000_0010);
    endtask

    initial begin
        #(8 * 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired R12 actual=hang expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cfg_sten_on = 1'b1; cfg_has_smode = 1'b1; cfg_rv64 = 1'b1;
        priv = 2'b11; virt = 1'b0;
        sten_wr_en = 1'b0; sten_wr_level = 2'd0; sten_wr_hi = 1'b0; sten_wr_data = '0;
        sten_rd_level = 2'd0;
        acc_valid = 1'b0; acc_write = 1'b0; acc_target = 2'd0; acc_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sten_mask();
        t_machine();
        t_disabled();
        t_mlevel();
        t_hlevel();
        t_slevel();
        t_order();
        t_senv();
        t_henv();
        t_henvh();
        t_fault_nowrite();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule